// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block holds the software-visible state of every channel of a descriptor-driven DMA engine. Each channel has a status word, a command pointer and three condition-select words. Software reaches them through a 32-bit register port with byte addresses. Each channel sits in its own 128-byte window, and the channel number is the address shifted right by seven. Descriptor fetch and data movement belong to a separate sequencer. That sequencer reads the status, the pointer and the condition results from this block, and it reports kill, stop and branch-taken events back so the status stays current.

Software never writes the status word directly. It writes a control word instead, and that word carries a per-bit write mask in its upper half. Once the masked merge is done, fixed priority rules derive the ACTIVE and DEAD flags from RUN, WAKE and PAUSE. Each control write returns two one-cycle pulses to the sequencer. The start pulse tells it the channel is active, and the flush pulse tells it a flush was requested.

Top module: `dma_csr`

## Requirements
- R1: The byte address selects channel `addr[AW-1:7]` and word `addr[6:2]`. Word indices 16 to 31 are not registers: they read as zero, and writing them changes nothing.
- R2: A write to word 0 (control) merges into the status as `(value & mask) | (old & ~mask)`. The mask is bits 31:16 and the value is bits 15:0. Only RUN (bit 15), PAUSE (14), FLUSH (13), WAKE (12) and the device bits 7:0 take the written value. A masked DEAD (11), ACTIVE (10) or branch-taken (8) bit becomes 0, and unmasked bits keep their old value.
- R3: After the merge, WAKE or RUN sets ACTIVE and RUN clears DEAD. PAUSE then clears ACTIVE and takes priority over both.
- R4: A control write that takes RUN from 1 to 0 clears ACTIVE and DEAD.
- R5: The cycle after a control write, `start_pulse` is high for one cycle if the resulting ACTIVE is set. In the same way, `flush_pulse` is high if the resulting FLUSH is set. Neither pulse fires without a control write.
- R6: Word 0, word 2 (pointer high) and words 7 to 15 always read as zero. Word 1 reads the status, word 3 the command pointer, and words 4, 5 and 6 the interrupt, branch and wait selects as last written.
- R7: A write to word 3 is ignored while RUN or ACTIVE is set. An accepted write stores the data with bits 3:0 cleared. Writes to word 1 are ignored.
- R8: `seq_kill` sets DEAD, clears ACTIVE and gives a one-cycle `irq_pulse` in the following cycle. It applies after a same-cycle stop or control write.
- R9: `seq_stop` clears ACTIVE, DEAD and FLUSH.
- R10: `seq_adv` loads `seq_taken` into status bit 8 (branch-taken).
- R11: `ch_cond[3c+0]`, `[3c+1]` and `[3c+2]` are the interrupt, branch and wait conditions of channel c. Each is 1 when `(status[3:0] & sel[19:16]) == (sel[3:0] & sel[19:16])`, computed from the present register contents.
- R12: Reset clears every register of every channel and all pulses.
- R13: Writes and events aimed at one channel leave every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address (channel, word) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| seq_kill | input | NCH | Per-channel kill event |
| seq_stop | input | NCH | Per-channel stop event |
| seq_adv | input | NCH | Per-channel pointer-advance event |
| seq_taken | input | NCH | Branch-taken value loaded on advance |
| start_pulse | output | NCH | Channel activated by a control write |
| flush_pulse | output | NCH | Flush requested by a control write |
| irq_pulse | output | NCH | Interrupt raised by a kill |
| ch_status | output | 16*NCH | Status word of each channel |
| ch_cmdptr | output | 32*NCH | Command pointer of each channel |
| ch_cond | output | 3*NCH | Interrupt, branch and wait condition results |

## Verification
All status state can be read back through word 1 and `ch_status`, so a bad merge or a wrong derivation rule shows up on the port right after the write edge. The same applies to a kill or stop applied in the wrong order. A wrong start, flush or interrupt decision shows up as a pulse that is present or missing in that same cycle. A stored pointer or select that is wrong appears in the readback and in `ch_cond` at once, with no delay.

// File: rtl/dma_csr_pkg.sv
`timescale 1ns/1ps
package dma_csr_pkg;

    localparam int CHAN_BYTES_LOG2 = 7;

    localparam logic [4:0] W_CTRL  = 5'd0;
    localparam logic [4:0] W_STAT  = 5'd1;
    localparam logic [4:0] W_PTRHI = 5'd2;
    localparam logic [4:0] W_PTRLO = 5'd3;
    localparam logic [4:0] W_ISEL  = 5'd4;
    localparam int         NUM_SEL = 3;

    localparam logic [15:0] CTL_WRITABLE = 16'hF0FF;

    typedef struct packed {
        logic       run;
        logic       pause;
        logic       flush;
        logic       wake;
        logic       dead;
        logic       active;
        logic       spare;
        logic       bt;
        logic [7:0] dev;
    } chan_status_t;

    function automatic chan_status_t ctl_apply(chan_status_t old, logic [31:0] wd);
        logic [15:0]  m;
        logic [15:0]  v;
        logic [15:0]  o;
        chan_status_t s;
        m = wd[31:16];
        v = wd[15:0] & CTL_WRITABLE;
        o = old;
        s = chan_status_t'((v & m) | (o & ~m));
        if (s.wake) s.active = 1'b1;
        if (s.run) begin
            s.active = 1'b1;
            s.dead   = 1'b0;
        end
        if (s.pause) s.active = 1'b0;
        if (old.run && !s.run) begin
            s.active = 1'b0;
            s.dead   = 1'b0;
        end
        return s;
    endfunction

    function automatic logic sel_hit(logic [3:0] dev_lo, logic [3:0] msk, logic [3:0] val);
        return (dev_lo & msk) == (val & msk);
    endfunction

endpackage

// File: rtl/dma_csr_sel_match.sv
`timescale 1ns/1ps
module dma_csr_sel_match
    import dma_csr_pkg::*;
(
    input  logic [3:0] dev_lo,
    input  logic [3:0] sel_mask,
    input  logic [3:0] sel_val,
    output logic       hit
);
    assign hit = sel_hit(dev_lo, sel_mask, sel_val);
endmodule

// File: rtl/dma_csr_chan.sv
`timescale 1ns/1ps
module dma_csr_chan
    import dma_csr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [4:0]                 word,
    input  logic [31:0]                wdata,
    output logic [31:0]                rd_data,
    input  logic                       kill,
    input  logic                       stop,
    input  logic                       adv,
    input  logic                       taken,
    output chan_status_t               status_o,
    output logic [31:0]                cmdptr_o,
    output logic [NUM_SEL-1:0][31:0]   sel_o,
    output logic                       start_o,
    output logic                       flush_o,
    output logic                       irq_o
);
    chan_status_t                stat_q, stat_d;
    logic [31:0]                 ptr_q;
    logic [NUM_SEL-1:0][31:0]    sel_q;
    logic                        is_ctl;
    logic                        ptr_lock;

    assign is_ctl   = wr_en && (word == W_CTRL);
    assign ptr_lock = stat_q.run || stat_q.active;

    always_comb begin
        stat_d = stat_q;
        if (is_ctl) stat_d = ctl_apply(stat_q, wdata);
        if (adv)    stat_d.bt = taken;
        if (stop) begin
            stat_d.active = 1'b0;
            stat_d.dead   = 1'b0;
            stat_d.flush  = 1'b0;
        end
        if (kill) begin
            stat_d.dead   = 1'b1;
            stat_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            ptr_q   <= '0;
            sel_q   <= '0;
            start_o <= 1'b0;
            flush_o <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            stat_q  <= stat_d;
            start_o <= is_ctl && stat_d.active;
            flush_o <= is_ctl && stat_d.flush;
            irq_o   <= kill;
            if (wr_en && (word == W_PTRLO) && !ptr_lock)
                ptr_q <= {wdata[31:4], 4'b0000};
            for (int j = 0; j < NUM_SEL; j++) begin
                if (wr_en && (word == W_ISEL + 5'(j)))
                    sel_q[j] <= wdata;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (word == W_STAT)       rd_data = {16'h0000, stat_q};
        else if (word == W_PTRLO) rd_data = ptr_q;
        else begin
            for (int j = 0; j < NUM_SEL; j++)
                if (word == W_ISEL + 5'(j)) rd_data = sel_q[j];
        end
    end

    assign status_o = stat_q;
    assign cmdptr_o = ptr_q;
    assign sel_o    = sel_q;
endmodule

// File: rtl/dma_csr.sv
`timescale 1ns/1ps
module dma_csr
    import dma_csr_pkg::*;
#(
    parameter int NCH  = 4,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW   = CH_W + CHAN_BYTES_LOG2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [AW-1:0]        reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NCH-1:0]       seq_kill,
    input  logic [NCH-1:0]       seq_stop,
    input  logic [NCH-1:0]       seq_adv,
    input  logic [NCH-1:0]       seq_taken,
    output logic [NCH-1:0]       start_pulse,
    output logic [NCH-1:0]       flush_pulse,
    output logic [NCH-1:0]       irq_pulse,
    output logic [16*NCH-1:0]    ch_status,
    output logic [32*NCH-1:0]    ch_cmdptr,
    output logic [3*NCH-1:0]     ch_cond
);
    logic [CH_W-1:0] ch_idx;
    logic [4:0]      word;
    logic            unused_byte_lanes;

    assign ch_idx            = reg_addr[AW-1:CHAN_BYTES_LOG2];
    assign word              = reg_addr[6:2];
    assign unused_byte_lanes = ^reg_addr[1:0];

    chan_status_t               st     [NCH];
    logic [NUM_SEL-1:0][31:0]   sels   [NCH];
    logic [31:0]                rd_arr [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [31:0] ptr_w;

        dma_csr_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (reg_wr && (ch_idx == CH_W'(i))),
            .word     (word),
            .wdata    (reg_wdata),
            .rd_data  (rd_arr[i]),
            .kill     (seq_kill[i]),
            .stop     (seq_stop[i]),
            .adv      (seq_adv[i]),
            .taken    (seq_taken[i]),
            .status_o (st[i]),
            .cmdptr_o (ptr_w),
            .sel_o    (sels[i]),
            .start_o  (start_pulse[i]),
            .flush_o  (flush_pulse[i]),
            .irq_o    (irq_pulse[i])
        );

        assign ch_status[16*i +: 16] = st[i];
        assign ch_cmdptr[32*i +: 32] = ptr_w;

        for (genvar j = 0; j < NUM_SEL; j++) begin : g_sel
            dma_csr_sel_match u_match (
                .dev_lo   (st[i].dev[3:0]),
                .sel_mask (sels[i][j][19:16]),
                .sel_val  (sels[i][j][3:0]),
                .hit      (ch_cond[3*i + j])
            );
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (ch_idx == CH_W'(i)) reg_rdata = rd_arr[i];
    end
endmodule

// File: rtl/dma_csr_checker.sv
`timescale 1ns/1ps
module dma_csr_checker #(
    parameter int NCH = 4,
    parameter int AW  = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     reg_addr,
    input logic [31:0]       reg_rdata,
    input logic [NCH-1:0]    seq_kill,
    input logic [NCH-1:0]    seq_stop,
    input logic [NCH-1:0]    start_pulse,
    input logic [NCH-1:0]    flush_pulse,
    input logic [NCH-1:0]    irq_pulse,
    input logic [16*NCH-1:0] ch_status,
    input logic [32*NCH-1:0] ch_cmdptr
);
    assert_ctrl_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[6:2] == 5'd0) |-> (reg_rdata == 32'h0));

    assert_reset_clears_R12: assert property (@(posedge clk)
        rst |=> (ch_status == '0) && (start_pulse == '0) && (irq_pulse == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_kill_dead_R8: assert property (@(posedge clk) disable iff (rst)
            seq_kill[i] |=> ch_status[16*i+11] && !ch_status[16*i+10] && irq_pulse[i]);

        assert_stop_clears_R9: assert property (@(posedge clk) disable iff (rst)
            (seq_stop[i] && !seq_kill[i]) |=>
                !ch_status[16*i+10] && !ch_status[16*i+11] && !ch_status[16*i+13]);

        assert_start_active_R5: assert property (@(posedge clk) disable iff (rst)
            start_pulse[i] |-> ch_status[16*i+10]);

        assert_flush_set_R5: assert property (@(posedge clk) disable iff (rst)
            flush_pulse[i] |-> ch_status[16*i+13]);

        assert_ptr_locked_R7: assert property (@(posedge clk) disable iff (rst)
            (ch_status[16*i+15] || ch_status[16*i+10]) |=> $stable(ch_cmdptr[32*i +: 32]));
    end
endmodule

bind dma_csr dma_csr_checker #(.NCH(NCH), .AW(AW)) u_dma_csr_checker (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .seq_kill    (seq_kill),
    .seq_stop    (seq_stop),
    .start_pulse (start_pulse),
    .flush_pulse (flush_pulse),
    .irq_pulse   (irq_pulse),
    .ch_status   (ch_status),
    .ch_cmdptr   (ch_cmdptr)
);

// File: tb/dma_csr_bench.sv
`timescale 1ns/1ps
module dma_csr_bench;
    localparam int NCH = 4;
    localparam int AW  = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NCH-1:0]    seq_kill = '0, seq_stop = '0, seq_adv = '0, seq_taken = '0;
    logic [NCH-1:0]    start_pulse, flush_pulse, irq_pulse;
    logic [16*NCH-1:0] ch_status;
    logic [32*NCH-1:0] ch_cmdptr;
    logic [3*NCH-1:0]  ch_cond;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dma_csr #(.NCH(NCH)) u_dma_csr (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seq_kill(seq_kill), .seq_stop(seq_stop), .seq_adv(seq_adv), .seq_taken(seq_taken),
        .start_pulse(start_pulse), .flush_pulse(flush_pulse), .irq_pulse(irq_pulse),
        .ch_status(ch_status), .ch_cmdptr(ch_cmdptr), .ch_cond(ch_cond)
    );

    function automatic logic [AW-1:0] addr_of(int c, int w);
        return AW'(c * 128 + w * 4);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(int c, int w, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = addr_of(c, w); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int c, int w, output logic [31:0] d);
        reg_addr = addr_of(c, w);
        #0.5;
        d = reg_rdata;
    endtask

    task automatic ev(logic [NCH-1:0] k, logic [NCH-1:0] s, logic [NCH-1:0] a, logic [NCH-1:0] t);
        @(negedge clk);
        seq_kill = k; seq_stop = s; seq_adv = a; seq_taken = t;
        @(negedge clk);
        seq_kill = '0; seq_stop = '0; seq_adv = '0; seq_taken = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R12 status bus", 32'(ch_status[31:0]), 32'h0);
        check("R12 pulses", 32'({start_pulse, flush_pulse, irq_pulse}), 32'h0);
        for (int c = 0; c < NCH; c++) begin
            rd(c, 3, d); check("R12 cmdptr", d, 32'h0);
        end
    endtask

    task automatic t_run_and_ptr();
        logic [31:0] d;
        wr(0, 3, 32'h0000_1008);
        rd(0, 3, d); check("R7 ptr low bits cleared", d, 32'h0000_1000);
        wr(0, 0, 32'h8000_8000);
        rd(0, 1, d); check("R3 run sets active", d, 32'h8400);
        check("R5 start pulse on run", 32'(start_pulse[0]), 32'h1);
        check("R5 no flush pulse", 32'(flush_pulse[0]), 32'h0);
        wr(0, 3, 32'h0000_2000);
        rd(0, 3, d); check("R7 ptr write ignored while running", d, 32'h0000_1000);
        wr(0, 0, 32'h4000_4000);
        rd(0, 1, d); check("R3 pause clears active", d, 32'hC000);
        check("R5 no start when paused", 32'(start_pulse[0]), 32'h0);
    endtask

    task automatic t_kill_run_fall();
        logic [31:0] d;
        wr(2, 0, 32'h8000_8000);
        ev(4'b0100, '0, '0, '0);
        rd(2, 1, d); check("R8 kill sets dead clears active", d, 32'h8800);
        check("R8 irq pulse", 32'(irq_pulse[2]), 32'h1);
        wr(2, 0, 32'h8000_8000);
        rd(2, 1, d); check("R3 run clears dead", d, 32'h8400);
        wr(2, 0, 32'h8000_0000);
        rd(2, 1, d); check("R4 run fall clears active and dead", d, 32'h0000);
        check("R5 no start after run fall", 32'(start_pulse[2]), 32'h0);
    endtask

    task automatic t_wake_flush_stop();
        logic [31:0] d;
        wr(3, 0, 32'h1000_1000);
        rd(3, 1, d); check("R3 wake sets active", d, 32'h1400);
        check("R5 start on wake", 32'(start_pulse[3]), 32'h1);
        wr(3, 0, 32'h2000_2000);
        rd(3, 1, d); check("R2 flush merged", d, 32'h3400);
        check("R5 flush pulse", 32'(flush_pulse[3]), 32'h1);
        ev('0, 4'b1000, '0, '0);
        rd(3, 1, d); check("R9 stop clears active dead flush", d, 32'h1000);
        check("R5 no pulse without control write", 32'(start_pulse[3] | flush_pulse[3]), 32'h0);
    endtask

    task automatic t_merge_bt();
        logic [31:0] d;
        wr(1, 0, 32'h00FF_00A5);
        rd(1, 1, d); check("R2 device bits written", d, 32'h00A5);
        wr(1, 0, 32'h000F_FFF0);
        rd(1, 1, d); check("R2 only masked bits change", d, 32'h00A0);
        ev(4'b0010, '0, '0, '0);
        rd(1, 1, d); check("R8 kill on idle channel", d, 32'h08A0);
        wr(1, 0, 32'h0800_0800);
        rd(1, 1, d); check("R2 masked read-only bit cleared", d, 32'h00A0);
        ev('0, '0, 4'b0010, 4'b0010);
        rd(1, 1, d); check("R10 branch taken set", d, 32'h01A0);
        ev('0, '0, 4'b0010, 4'b0000);
        rd(1, 1, d); check("R10 branch taken cleared", d, 32'h00A0);
    endtask

    task automatic t_cond();
        logic [31:0] d;
        wr(1, 4, 32'h000F_0000);
        wr(1, 5, 32'h000F_0001);
        wr(1, 6, 32'h0000_0000);
        check("R11 conditions dev=0", 32'(ch_cond[5:3]), 32'b101);
        wr(1, 0, 32'h000F_0001);
        check("R11 conditions dev=1", 32'(ch_cond[5:3]), 32'b110);
        rd(1, 4, d); check("R6 interrupt select readback", d, 32'h000F_0000);
        rd(1, 5, d); check("R6 branch select readback", d, 32'h000F_0001);
    endtask

    task automatic t_zero_words();
        logic [31:0] d;
        wr(1, 2, 32'hFFFF_FFFF);
        wr(1, 7, 32'hFFFF_FFFF);
        wr(1, 15, 32'hFFFF_FFFF);
        wr(1, 20, 32'hFFFF_FFFF);
        wr(1, 1, 32'h0000_FFFF);
        rd(1, 0, d);  check("R6 control reads zero", d, 32'h0);
        rd(1, 2, d);  check("R6 pointer high reads zero", d, 32'h0);
        rd(1, 7, d);  check("R6 word 7 reads zero", d, 32'h0);
        rd(1, 15, d); check("R6 word 15 reads zero", d, 32'h0);
        rd(1, 20, d); check("R1 word 20 reads zero", d, 32'h0);
        rd(1, 1, d);  check("R7 status write ignored", d, 32'h00A1);
        rd(1, 6, d);  check("R1 out-of-range write left wait select", d, 32'h0);
    endtask

    task automatic t_priority_indep();
        logic [31:0] d;
        ev(4'b0001, 4'b0001, '0, '0);
        rd(0, 1, d); check("R8 kill wins over stop", d, 32'hC800);
        check("R8 irq pulse ch0", 32'(irq_pulse), 32'h1);
        rd(2, 1, d); check("R13 channel 2 untouched", d, 32'h0000);
        rd(3, 1, d); check("R13 channel 3 untouched", d, 32'h1000);
        rd(2, 3, d); check("R13 channel 2 ptr untouched", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_run_and_ptr();
        t_kill_run_fall();
        t_wake_flush_stop();
        t_merge_bt();
        t_cond();
        t_zero_words();
        t_priority_indep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R12 watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule